// File: doc/BRIEF.md
# Bit-Serial Constant-Coefficient FIR Filter

This block is a direct-form FIR filter whose coefficients are fixed when it is built. Each coefficient is a single signed power of two, ±2^-r. All arithmetic runs one bit per clock. Once per serial word of WS clocks, the block takes one parallel input sample. It sign-extends the sample and sends it out LSB first. A chain of bit delays, one serial word long per tap, holds the older samples. Each coefficient term picks one tap. It scales that tap by a left shift, which is a bit delay with zeros forced into the low bit positions of the word. A bit-serial negator is added when the sign is negative. A balanced tree of one-bit serial adders then sums all the terms.

The serial word is longer than the input word. It has RMAX + log2(NTERM) + 1 guard bits, so the sum of all terms is exact. Every adder clears its carry at the bit time where its operands' least significant bit arrives. That bit time is decoded from a single modulo-WS counter at the adder's path latency. The counter also paces the input capture. At the output, a serial-to-parallel stage gathers the root word. It shifts the word right by RMAX to bring it back to a fraction and saturates it to the input width. One result word appears every WS clocks.

Top module: `bsfir_core`

## Requirements
- R1: While rst is high, and in the first cycle after it falls, y_valid is 0 and y_out is 0.
- R2: x_take is high in the first cycle after reset and then exactly once every WS cycles, with WS = DW + RMAX + clog2(NTERM) + 1 (18 by default). x_in is captured at the clock edge that ends a cycle with x_take high.
- R3: For the n-th captured sample, the output is sat(floor(Σt sgn_t · x[n − TERM_TAP[t]] · 2^(−TERM_RSH[t]))). Here sgn_t is −1 when TERM_NEG[t] = 1 and +1 otherwise. The sum is exact. Results come out in capture order.
- R4: y_valid is a one-cycle pulse, repeated every WS cycles. The first pulse is visible WS + log2(LEAVES) + 2 cycles after the capture cycle of the first sample (22 by default). LEAVES is NTERM rounded up to a power of two. y_out holds its value between pulses.
- R5: A result above 2^(DW−1) − 1 is output as 2^(DW−1) − 1.
- R6: A result below −2^(DW−1) is output as −2^(DW−1).
- R7: Fractional results are rounded toward minus infinity. For example, the term 0.5 · (−1) gives −1, not 0.
- R8: Taps that reach back before the first captured sample contribute zero.
- R9: Tap j contributes the sample captured j words earlier. A single nonzero sample therefore produces the coefficients in tap order, one per output word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | DW | Signed input sample, captured when x_take is high |
| x_take | output | 1 | High in the cycle whose ending edge captures x_in |
| y_out | output | DW | Signed, saturated filter result |
| y_valid | output | 1 | One-cycle pulse marking a new y_out |

## Verification
The bench sends a single impulse. A wrong word delay or a wrong tap pick would show the coefficients in the wrong order or at the wrong scale. It drives long runs at the most positive and most negative input. A design that drops guard bits would wrap to the opposite sign there, and one without clamping would pass a truncated wrong value. Small negative inputs through the half-weight taps expose truncation toward zero in place of floor rounding. A misplaced adder carry-clear or a missing low-bit mask in a shifted term would leak bits between neighbouring words. A pseudo-random sequence then catches that leakage. The bench also times the first valid pulse and the spacing of the pulses, so an off-by-one in the capture phase cannot go unnoticed.

// File: rtl/bsfir_pkg.sv
package bsfir_pkg;

  function automatic int pow2_ceil(input int n);
    int p;
    p = 1;
    while (p < n) p = p * 2;
    return p;
  endfunction

  function automatic int guard_bits(input int nterm, input int rmax);
    return rmax + $clog2(nterm) + 1;
  endfunction

endpackage

// File: rtl/bsfir_front.sv
module bsfir_front #(
  parameter int DW   = 12,
  parameter int WS   = 18,
  parameter int TAPS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic signed [DW-1:0] x_in,
  output logic [TAPS-1:0]      taps
);
  logic [WS-1:0] sreg;

  // word-parallel sample in, LSB-first stream out, sign bit repeated at top
  always_ff @(posedge clk) begin
    if (rst)       sreg <= '0;
    else if (load) sreg <= {{(WS-DW){x_in[DW-1]}}, x_in};
    else           sreg <= {sreg[WS-1], sreg[WS-1:1]};
  end

  assign taps[0] = sreg[0];

  generate
    if (TAPS > 1) begin : g_line
      localparam int LW = (TAPS - 1) * WS;
      logic [LW-1:0] dl;
      always_ff @(posedge clk) begin
        if (rst) dl <= '0;
        else     dl <= (dl << 1) | LW'(sreg[0]);
      end
      for (genvar j = 1; j < TAPS; j++) begin : g_tap
        assign taps[j] = dl[j*WS-1];
      end
    end
  endgenerate
endmodule

// File: rtl/bsfir_term.sv
module bsfir_term #(
  parameter int WS  = 18,
  parameter int PW  = 5,
  parameter int SH  = 0,
  parameter bit NEG = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          din,
  input  logic [PW-1:0] pos,
  input  logic          first,
  output logic          dout
);
  localparam logic [WS-1:0] ZMASK = WS'((64'd1 << SH) - 64'd1);

  logic d;
  logic m;
  logic seen;
  logic seen_eff;

  generate
    if (SH == 0) begin : g_direct
      assign d = din;
    end else begin : g_shift
      logic [SH-1:0] dly;
      always_ff @(posedge clk) begin
        if (rst) dly <= '0;
        else     dly <= (dly << 1) | SH'(din);
      end
      assign d = dly[SH-1];
    end
  endgenerate

  // low SH bit positions of the frame carry the shifted-in zeros
  assign m        = ZMASK[pos] ? 1'b0 : d;
  assign seen_eff = first ? 1'b0 : seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= 1'b0;
      seen <= 1'b0;
    end else begin
      dout <= m ^ (NEG & seen_eff);
      seen <= seen_eff | m;
    end
  end
endmodule

// File: rtl/bsfir_sadd.sv
module bsfir_sadd (
  input  logic clk,
  input  logic rst,
  input  logic first,
  input  logic a,
  input  logic b,
  output logic s
);
  logic carry;
  logic c_eff;

  assign c_eff = first ? 1'b0 : carry;

  always_ff @(posedge clk) begin
    if (rst) begin
      s     <= 1'b0;
      carry <= 1'b0;
    end else begin
      s     <= a ^ b ^ c_eff;
      carry <= (a & b) | (a & c_eff) | (b & c_eff);
    end
  end
endmodule

// File: rtl/bsfir_back.sv
module bsfir_back #(
  parameter int DW   = 12,
  parameter int WS   = 18,
  parameter int RMAX = 3,
  parameter int PW   = 5,
  parameter int CAP  = 3,
  parameter int LIM  = 21
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PW-1:0]        cnt,
  input  logic                 sbit,
  output logic signed [DW-1:0] y_out,
  output logic                 y_valid
);
  localparam int FW = $clog2(LIM + 1);
  localparam logic signed [WS-1:0] HI = WS'((64'd1 << (DW - 1)) - 64'd1);
  localparam logic signed [WS-1:0] LO = ~HI;

  logic [WS-2:0]        acc;
  logic signed [WS-1:0] full;
  logic signed [WS-1:0] shr;
  logic [FW-1:0]        fill;
  logic                 cap;

  assign full = {sbit, acc};
  assign shr  = full >>> RMAX;
  assign cap  = (cnt == PW'(CAP)) && (fill == FW'(LIM));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      fill    <= '0;
      y_out   <= '0;
      y_valid <= 1'b0;
    end else begin
      acc     <= {sbit, acc[WS-2:1]};
      if (fill != FW'(LIM)) fill <= fill + 1'b1;
      y_valid <= cap;
      if (cap) begin
        if (shr > HI)      y_out <= HI[DW-1:0];
        else if (shr < LO) y_out <= LO[DW-1:0];
        else               y_out <= shr[DW-1:0];
      end
    end
  end
endmodule

// File: rtl/bsfir_core.sv
module bsfir_core #(
  parameter int DW    = 12,
  parameter int TAPS  = 4,
  parameter int NTERM = 4,
  parameter int RMAX  = 3,
  parameter int TERM_TAP [NTERM] = '{0, 1, 2, 3},
  parameter int TERM_RSH [NTERM] = '{0, 1, 3, 1},
  parameter bit TERM_NEG [NTERM] = '{1'b0, 1'b0, 1'b1, 1'b0}
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] x_in,
  output logic                 x_take,
  output logic signed [DW-1:0] y_out,
  output logic                 y_valid
);
  localparam int WS       = DW + bsfir_pkg::guard_bits(NTERM, RMAX);
  localparam int LEAVES   = bsfir_pkg::pow2_ceil(NTERM);
  localparam int DEPTH    = $clog2(LEAVES);
  localparam int PW       = $clog2(WS);
  localparam int ROOT_LAT = 2 + DEPTH;
  localparam int LIM      = WS - 1 + ROOT_LAT;
  localparam int CAP      = LIM % WS;

  logic [PW-1:0]       cnt;
  logic [PW-1:0]       pos1;
  logic [DEPTH:0]      lvl_start;
  logic [TAPS-1:0]     taps;
  logic [2*LEAVES-1:1] nodes;

  always_ff @(posedge clk) begin
    if (rst)                      cnt <= '0;
    else if (cnt == PW'(WS - 1))  cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end

  assign x_take = (cnt == '0);
  assign pos1   = (cnt == '0) ? PW'(WS - 1) : cnt - 1'b1;

  // level lv sees its operand LSBs at latency 1+lv from the load edge
  generate
    for (genvar lv = 0; lv <= DEPTH; lv++) begin : g_start
      assign lvl_start[lv] = (cnt == PW'((1 + lv) % WS));
    end
  endgenerate

  bsfir_front #(.DW(DW), .WS(WS), .TAPS(TAPS)) u_front (
    .clk(clk), .rst(rst), .load(x_take), .x_in(x_in), .taps(taps)
  );

  generate
    for (genvar t = 0; t < LEAVES; t++) begin : g_leaf
      if (t < NTERM) begin : g_term
        bsfir_term #(
          .WS(WS), .PW(PW), .SH(RMAX - TERM_RSH[t]), .NEG(TERM_NEG[t])
        ) u_term (
          .clk(clk), .rst(rst), .din(taps[TERM_TAP[t]]), .pos(pos1),
          .first(lvl_start[0]), .dout(nodes[LEAVES+t])
        );
      end else begin : g_pad
        assign nodes[LEAVES+t] = 1'b0;
      end
    end
    for (genvar i = 1; i < LEAVES; i++) begin : g_add
      localparam int LV = DEPTH - $clog2(i + 1) + 1;
      bsfir_sadd u_add (
        .clk(clk), .rst(rst), .first(lvl_start[LV]),
        .a(nodes[2*i]), .b(nodes[2*i+1]), .s(nodes[i])
      );
    end
  endgenerate

  bsfir_back #(
    .DW(DW), .WS(WS), .RMAX(RMAX), .PW(PW), .CAP(CAP), .LIM(LIM)
  ) u_back (
    .clk(clk), .rst(rst), .cnt(cnt), .sbit(nodes[1]),
    .y_out(y_out), .y_valid(y_valid)
  );
endmodule

// File: rtl/bsfir_core_chk.sv
module bsfir_core_chk #(
  parameter int DW    = 12,
  parameter int WS    = 18,
  parameter int DEPTH = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          x_take,
  input logic          y_valid,
  input logic [DW-1:0] y_out
);
  localparam int PW  = $clog2(WS);
  localparam int CL  = WS + DEPTH + 2;
  localparam int CW  = $clog2(CL + 1);

  logic [PW-1:0] ph;
  logic [CW-1:0] cyc;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= '0;
      cyc <= '0;
    end else begin
      ph <= (ph == PW'(WS - 1)) ? '0 : ph + 1'b1;
      if (cyc != CW'(CL)) cyc <= cyc + 1'b1;
    end
  end

  p_take_phase_r2: assert property (@(posedge clk) disable iff (rst)
    x_take == (ph == '0));

  p_valid_phase_r4: assert property (@(posedge clk) disable iff (rst)
    y_valid |-> (ph == PW'((DEPTH + 2) % WS)));

  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    y_valid |=> !y_valid);

  p_no_early_valid_r1: assert property (@(posedge clk) disable iff (rst)
    (cyc < CW'(CL)) |-> !y_valid);

  p_hold_out_r4: assert property (@(posedge clk) disable iff (rst)
    !y_valid |-> $stable(y_out));
endmodule

bind bsfir_core bsfir_core_chk #(.DW(DW), .WS(WS), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .x_take(x_take), .y_valid(y_valid), .y_out(y_out)
);

// File: tb/bsfir_core_bench.sv
module bsfir_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW    = 12;
  localparam int TAPS  = 4;
  localparam int NT    = 4;
  localparam int RB    = 3;
  localparam int WSB   = 18;
  localparam int DEPTHB = 2;
  localparam int TT [NT] = '{0, 1, 2, 3};
  localparam int TR [NT] = '{0, 1, 3, 1};
  localparam int TN [NT] = '{0, 0, 1, 0};
  localparam int YMAX = 2047;
  localparam int YMIN = -2048;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [DW-1:0] x_in = '0;
  logic x_take;
  logic signed [DW-1:0] y_out;
  logic y_valid;

  int checks = 0;
  int bad = 0;
  int exp_q[$];
  string tag_q[$];
  int hist[TAPS];
  bit tail = 1'b0;
  bit live = 1'b0;
  int pcnt = 0;
  int first_v = -1;
  int last_v = -1;
  int rng = 32'h1d2c3b4a;

  bsfir_core u_bsfir_core (
    .clk(clk), .rst(rst), .x_in(x_in), .x_take(x_take),
    .y_out(y_out), .y_valid(y_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    live <= !rst;
    if (rst) pcnt <= 0;
    else     pcnt <= pcnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic push_model(input int v, input string req);
    longint s;
    longint y;
    for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = v;
    s = 0;
    for (int t = 0; t < NT; t++) begin
      if (TN[t] != 0) s = s - longint'(hist[TT[t]]) * (longint'(1) <<< (RB - TR[t]));
      else            s = s + longint'(hist[TT[t]]) * (longint'(1) <<< (RB - TR[t]));
    end
    y = s >>> RB;
    if (y > YMAX) y = YMAX;
    if (y < YMIN) y = YMIN;
    exp_q.push_back(int'(y));
    tag_q.push_back(req);
  endtask

  task automatic send(input int v, input string req);
    @(negedge clk);
    while (!x_take) @(negedge clk);
    x_in = v[DW-1:0];
    push_model(v, req);
  endtask

  // monitor: scoreboard compare plus timing of x_take and y_valid
  always @(negedge clk) begin
    if (live) begin
      if ((pcnt % WSB == 0) || x_take)
        check(x_take == (pcnt % WSB == 0), "R2", int'(x_take), int'(pcnt % WSB == 0));
      if (y_valid) begin
        if (first_v < 0) begin
          first_v = pcnt;
          check(pcnt == WSB + DEPTHB + 2, "R4", pcnt, WSB + DEPTHB + 2);
        end else begin
          check(pcnt - last_v == WSB, "R4", pcnt - last_v, WSB);
        end
        last_v = pcnt;
        if (exp_q.size() > 0) begin
          int e;
          string r;
          e = exp_q.pop_front();
          r = tag_q.pop_front();
          check(int'(y_out) == e, r, int'(y_out), e);
        end else if (!tail) begin
          check(1'b0, "R3", int'(y_out), 0);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < TAPS; k++) hist[k] = 0;
    repeat (5) @(negedge clk);
    check(y_out == 0, "R1", int'(y_out), 0);
    check(y_valid == 1'b0, "R1", int'(y_valid), 0);
    // release reset; the capture edge right after takes x_in = 0
    rst = 1'b0;
    x_in = '0;
    push_model(0, "R8");
    @(negedge clk);
    check(y_out == 0, "R1", int'(y_out), 0);
    check(y_valid == 1'b0, "R1", int'(y_valid), 0);
    // impulse: coefficients in tap order, scaled by 1024
    send(1024, "R9");
    for (int k = 0; k < 4; k++) send(0, "R9");
    // small negatives: floor rounding on half and eighth weights
    send(-1, "R7");
    send(0, "R7");
    send(0, "R7");
    send(-3, "R7");
    send(5, "R7");
    for (int k = 0; k < 4; k++) send(0, "R7");
    // upper clamp
    for (int k = 0; k < 6; k++) send(2047, "R5");
    send(2000, "R5");
    // lower clamp
    for (int k = 0; k < 6; k++) send(-2048, "R6");
    send(-1900, "R6");
    // alternating extremes
    for (int k = 0; k < 6; k++) send((k % 2 == 0) ? 2047 : -2048, "R3");
    // pseudo-random words
    for (int k = 0; k < 40; k++) begin
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >>> 17);
      rng = rng ^ (rng << 5);
      send((rng % 4096 + 4096) % 4096 - 2048, "R3");
    end
    tail = 1'b1;
    while (exp_q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule